// File: doc/BRIEF.md
# Message-Signaled Interrupt File Controller

This block is the interrupt file that sits beside one hart. Devices raise interrupts by posting a 32-bit write of an identity number into a small memory-mapped page. The file keeps one pending bit and one enable bit for every implemented identity. It continuously picks the lowest-numbered identity that is both pending and enabled, which is the one with the highest priority. It raises a registered external interrupt line when delivery is switched on and such an identity exists.

Software reaches the file through an indirect register port: an 8-bit select, a write strobe, write data and combinational read data. Through this port it sets the delivery switch and the threshold, reads or claims the top interrupt, and reads or writes the pending and enable bits as 32-bit slices. A claim is a write to the top-interrupt select. In that cycle the read data shows the current top value, and the pending bit of that identity is cleared at the clock edge. Three by-number ports set an enable bit, clear an enable bit, or clear a pending bit from an identity number, with no read-modify-write.

The identity count `NUM_IDS` must lie between 63 and 2047 and take the form 64·k − 1. The default is 63.

Top module: `msi_file_ctrl`

## Requirements
- R1: After reset all pending and enable bits are 0, delivery is off, the threshold is 0, `ext_irq` is 0 and the top-interrupt select (0x76) reads 0.
- R2: A message at page offset 0x000 sets the pending bit of the identity given by `msg_data` as presented. A message at offset 0x004 sets the pending bit of the identity given by `msg_data` with its four bytes reversed. A message at any other offset changes nothing.
- R3: A message carrying identity 0 or any value above `NUM_IDS` changes nothing. Bit 0 of pending slice 0 and bit 0 of enable slice 0 always read 0, even after a write of all ones.
- R4: Select 0x80+w reads and writes pending bits for identities 32w to 32w+31, and select 0xC0+w does the same for enable bits. Bit b of a slice is identity 32w+b, and a write replaces the whole slice. Slices beyond `(NUM_IDS+1)/32` read 0 and ignore writes.
- R5: Select 0x76 reads the top identity in bits 26:16 and the same number as priority in bits 10:0. The top identity is the lowest-numbered identity that is pending, enabled and not masked. The select reads 0 when no identity qualifies.
- R6: Select 0x72 holds an 11-bit threshold T. T = 0 masks nothing. A nonzero T masks every identity numbered T or higher.
- R7: Select 0x70 bit 0 is the delivery switch. `ext_irq` is 1 in a cycle exactly when, at the previous clock edge, delivery was on and the top value was nonzero.
- R8: A write to select 0x76 returns the current top value on `reg_rdata` in that cycle and clears that identity's pending bit at the edge. Repeated claims drain the eligible identities in ascending order until the select reads 0.
- R9: `seten_*` sets one enable bit, `clren_*` clears one enable bit and `clrpend_*` clears one pending bit, each selected by number. Numbers 0 or above `NUM_IDS` change nothing.
- R10: When a message sets the same identity that a claim clears in the same cycle, the pending bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Message write strobe into the page |
| msg_addr | input | PAGE_AW | Byte offset of the message within the page |
| msg_data | input | 32 | Message payload carrying the identity |
| reg_sel | input | 8 | Indirect register select |
| reg_wr | input | 1 | Indirect register write (claim when the select is 0x76) |
| reg_wdata | input | 32 | Indirect register write data |
| reg_rdata | output | 32 | Indirect register read data for the current select |
| seten_valid | input | 1 | Set-enable-by-number strobe |
| seten_num | input | 11 | Identity whose enable bit is set |
| clren_valid | input | 1 | Clear-enable-by-number strobe |
| clren_num | input | 11 | Identity whose enable bit is cleared |
| clrpend_valid | input | 1 | Clear-pending-by-number strobe |
| clrpend_num | input | 11 | Identity whose pending bit is cleared |
| ext_irq | output | 1 | Registered external interrupt request to the hart |

## Verification
Several rules are checked on every cycle against internal state. `ext_irq` must follow the previous edge's delivery switch and top value. Identity 0 must never hold a pending or enable bit. A reported top identity must be pending, enabled and below a nonzero threshold. A claim must clear the reported bit unless a message for the same identity arrives in that cycle, in which case the bit must survive. Other behaviour can only be shown by the bench's directed scenarios. These cover byte-order decoding and offset rejection, out-of-range identities, the slice mapping and slices above the implemented range, and the lowest-number-first choice under different threshold values. They also cover the drain order of repeated claims and the by-number ports' rejection of invalid numbers.

// File: rtl/msi_file_pkg.sv
// Shared constants and helpers for the message-signaled interrupt file.
// Assumes identities fit the 11-bit field of the top-interrupt register.
package msi_file_pkg;
    localparam int TOP_W  = 11;
    localparam int WORD_W = 32;
    localparam int WIDX_W = 6;

    localparam logic [7:0] SEL_DELIVER = 8'h70;
    localparam logic [7:0] SEL_THRESH  = 8'h72;
    localparam logic [7:0] SEL_TOPCLM  = 8'h76;
    localparam logic [1:0] GRP_PEND    = 2'b10;
    localparam logic [1:0] GRP_ENAB    = 2'b11;

    localparam int OFS_LITTLE = 0;
    localparam int OFS_BIG    = 4;

    // True when num names an implemented identity (1..max_id).
    function automatic logic id_valid(input logic [31:0] num, input int unsigned max_id);
        return (num != 32'd0) && (num <= max_id);
    endfunction

    // Reverses the byte order of a 32-bit word.
    function automatic logic [31:0] swap_bytes(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    // Packs identity and priority into the top-interrupt register layout.
    function automatic logic [WORD_W-1:0] top_word(input logic [TOP_W-1:0] id);
        return {5'b0, id, 5'b0, id};
    endfunction
endpackage

// File: rtl/msi_msg_decode.sv
// Decodes a message write into the page into a single pending-set request.
// Offset OFS_LITTLE takes the payload as presented, OFS_BIG byte-reverses it.
// Assumes at most one message per cycle; invalid identities are dropped.
module msi_msg_decode
    import msi_file_pkg::*;
#(
    parameter int NUM_IDS = 63,
    parameter int IDW     = 6,
    parameter int PAGE_AW = 12
) (
    input  logic               msg_valid,
    input  logic [PAGE_AW-1:0] msg_addr,
    input  logic [31:0]        msg_data,
    output logic               set_v,
    output logic [IDW-1:0]     set_id
);
    logic        hit;
    logic [31:0] raw;

    // Select the byte order from the page offset.
    always_comb begin
        hit = 1'b0;
        raw = '0;
        if (msg_valid && (msg_addr == PAGE_AW'(OFS_LITTLE))) begin
            hit = 1'b1;
            raw = msg_data;
        end else if (msg_valid && (msg_addr == PAGE_AW'(OFS_BIG))) begin
            hit = 1'b1;
            raw = swap_bytes(msg_data);
        end
    end

    assign set_v  = hit && id_valid(raw, NUM_IDS);
    assign set_id = raw[IDW-1:0];
endmodule

// File: rtl/msi_id_array.sv
// Pending and enable storage, one flop pair per implemented identity.
// Identity 0 is tied to zero. Update order per pending bit: slice write,
// clear-by-number, claim clear, then message set (the set wins).
// Assumes request identities are already range-checked.
module msi_id_array
    import msi_file_pkg::*;
#(
    parameter int NBITS = 64,
    parameter int IDW   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_wr,
    input  logic              en_wr,
    input  logic [WIDX_W-1:0] word_idx,
    input  logic [WORD_W-1:0] word_data,
    input  logic              set_pend_v,
    input  logic [IDW-1:0]    set_pend_id,
    input  logic              clr_pend_v,
    input  logic [IDW-1:0]    clr_pend_id,
    input  logic              claim_v,
    input  logic [IDW-1:0]    claim_id,
    input  logic              set_en_v,
    input  logic [IDW-1:0]    set_en_id,
    input  logic              clr_en_v,
    input  logic [IDW-1:0]    clr_en_id,
    output logic [NBITS-1:0]  pend_vec,
    output logic [NBITS-1:0]  en_vec
);
    for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
        if (gi == 0) begin : g_absent
            assign pend_vec[gi] = 1'b0;
            assign en_vec[gi]   = 1'b0;
        end else begin : g_live
            localparam logic [IDW-1:0]    MY_ID   = IDW'(gi);
            localparam logic [WIDX_W-1:0] MY_WORD = WIDX_W'(gi / WORD_W);
            localparam int                MY_BIT  = gi % WORD_W;
            logic pend_q;
            logic en_q;

            // Pending bit: later statements take precedence.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                end else begin
                    if (pend_wr && (word_idx == MY_WORD)) pend_q <= word_data[MY_BIT];
                    if (clr_pend_v && (clr_pend_id == MY_ID)) pend_q <= 1'b0;
                    if (claim_v && (claim_id == MY_ID)) pend_q <= 1'b0;
                    if (set_pend_v && (set_pend_id == MY_ID)) pend_q <= 1'b1;
                end
            end

            // Enable bit: slice write, then set-by-number, then clear-by-number.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q <= 1'b0;
                end else begin
                    if (en_wr && (word_idx == MY_WORD)) en_q <= word_data[MY_BIT];
                    if (set_en_v && (set_en_id == MY_ID)) en_q <= 1'b1;
                    if (clr_en_v && (clr_en_id == MY_ID)) en_q <= 1'b0;
                end
            end

            assign pend_vec[gi] = pend_q;
            assign en_vec[gi]   = en_q;
        end
    end
endmodule

// File: rtl/msi_top_select.sv
// Combinational search for the lowest-numbered identity that is pending,
// enabled and under the threshold (threshold 0 disables masking).
// Outputs 0 when nothing qualifies. Depth grows linearly with NBITS.
module msi_top_select
    import msi_file_pkg::*;
#(
    parameter int NBITS = 64
) (
    input  logic [NBITS-1:0] pend_vec,
    input  logic [NBITS-1:0] en_vec,
    input  logic [TOP_W-1:0] thr,
    output logic [TOP_W-1:0] top_id
);
    // Scan downward so the last match kept is the lowest number.
    always_comb begin
        top_id = '0;
        for (int i = NBITS - 1; i >= 1; i--) begin
            if (pend_vec[i] && en_vec[i] && ((thr == '0) || (i < int'(thr)))) begin
                top_id = TOP_W'(i);
            end
        end
    end
endmodule

// File: rtl/msi_reg_port.sv
// Indirect register port: holds delivery and threshold, decodes slice
// writes and claims, and muxes read data for the current select.
// Assumes one access per cycle; read data is combinational.
module msi_reg_port
    import msi_file_pkg::*;
#(
    parameter int NBITS  = 64,
    parameter int NWORDS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [TOP_W-1:0]  low_wdata,
    input  logic [NBITS-1:0]  pend_vec,
    input  logic [NBITS-1:0]  en_vec,
    input  logic [TOP_W-1:0]  top_id,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              deliver_q,
    output logic [TOP_W-1:0]  thr_q,
    output logic              pend_wr,
    output logic              en_wr,
    output logic [WIDX_W-1:0] word_idx,
    output logic              claim_v
);
    logic [1:0] grp;

    assign grp      = reg_sel[7:6];
    assign word_idx = reg_sel[WIDX_W-1:0];
    assign pend_wr  = reg_wr && (grp == GRP_PEND);
    assign en_wr    = reg_wr && (grp == GRP_ENAB);
    assign claim_v  = reg_wr && (reg_sel == SEL_TOPCLM) && (top_id != '0);

    // Delivery switch and threshold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deliver_q <= 1'b0;
            thr_q     <= '0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_DELIVER) deliver_q <= low_wdata[0];
            if (reg_sel == SEL_THRESH)  thr_q     <= low_wdata;
        end
    end

    // Read mux over scalar registers and implemented slices.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_DELIVER: reg_rdata = WORD_W'(deliver_q);
            SEL_THRESH:  reg_rdata = WORD_W'(thr_q);
            SEL_TOPCLM:  reg_rdata = top_word(top_id);
            default:     reg_rdata = '0;
        endcase
        for (int w = 0; w < NWORDS; w++) begin
            if ((grp == GRP_PEND) && (word_idx == WIDX_W'(w))) reg_rdata = pend_vec[w*WORD_W +: WORD_W];
            if ((grp == GRP_ENAB) && (word_idx == WIDX_W'(w))) reg_rdata = en_vec[w*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/msi_file_ctrl.sv
// Per-hart interrupt file: message decode, identity storage, top search,
// indirect register port and a registered interrupt line.
// Assumes NUM_IDS is 64k-1 within 63..2047.
module msi_file_ctrl
    import msi_file_pkg::*;
#(
    parameter int NUM_IDS = 63,
    parameter int PAGE_AW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_valid,
    input  logic [PAGE_AW-1:0] msg_addr,
    input  logic [31:0]        msg_data,
    input  logic [7:0]         reg_sel,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               seten_valid,
    input  logic [10:0]        seten_num,
    input  logic               clren_valid,
    input  logic [10:0]        clren_num,
    input  logic               clrpend_valid,
    input  logic [10:0]        clrpend_num,
    output logic               ext_irq
);
    localparam int NBITS  = NUM_IDS + 1;
    localparam int NWORDS = NBITS / WORD_W;
    localparam int IDW    = $clog2(NBITS);

    logic              msg_set_v;
    logic [IDW-1:0]    msg_set_id;
    logic [NBITS-1:0]  pend_vec;
    logic [NBITS-1:0]  en_vec;
    logic [TOP_W-1:0]  top_id;
    logic [TOP_W-1:0]  thr_q;
    logic              deliver_q;
    logic              pend_wr;
    logic              en_wr;
    logic [WIDX_W-1:0] word_idx;
    logic              claim_v;
    logic              seten_ok;
    logic              clren_ok;
    logic              clrpend_ok;

    assign seten_ok   = seten_valid   && id_valid(32'(seten_num),   NUM_IDS);
    assign clren_ok   = clren_valid   && id_valid(32'(clren_num),   NUM_IDS);
    assign clrpend_ok = clrpend_valid && id_valid(32'(clrpend_num), NUM_IDS);

    msi_msg_decode #(.NUM_IDS(NUM_IDS), .IDW(IDW), .PAGE_AW(PAGE_AW)) u_dec (
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data),
        .set_v     (msg_set_v),
        .set_id    (msg_set_id)
    );

    msi_id_array #(.NBITS(NBITS), .IDW(IDW)) u_arr (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_wr     (pend_wr),
        .en_wr       (en_wr),
        .word_idx    (word_idx),
        .word_data   (reg_wdata),
        .set_pend_v  (msg_set_v),
        .set_pend_id (msg_set_id),
        .clr_pend_v  (clrpend_ok),
        .clr_pend_id (clrpend_num[IDW-1:0]),
        .claim_v     (claim_v),
        .claim_id    (top_id[IDW-1:0]),
        .set_en_v    (seten_ok),
        .set_en_id   (seten_num[IDW-1:0]),
        .clr_en_v    (clren_ok),
        .clr_en_id   (clren_num[IDW-1:0]),
        .pend_vec    (pend_vec),
        .en_vec      (en_vec)
    );

    msi_top_select #(.NBITS(NBITS)) u_sel (
        .pend_vec (pend_vec),
        .en_vec   (en_vec),
        .thr      (thr_q),
        .top_id   (top_id)
    );

    msi_reg_port #(.NBITS(NBITS), .NWORDS(NWORDS)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .low_wdata (reg_wdata[TOP_W-1:0]),
        .pend_vec  (pend_vec),
        .en_vec    (en_vec),
        .top_id    (top_id),
        .reg_rdata (reg_rdata),
        .deliver_q (deliver_q),
        .thr_q     (thr_q),
        .pend_wr   (pend_wr),
        .en_wr     (en_wr),
        .word_idx  (word_idx),
        .claim_v   (claim_v)
    );

    // Registered interrupt request to the hart.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_irq <= 1'b0;
        else        ext_irq <= deliver_q && (top_id != '0);
    end
endmodule

// File: rtl/msi_file_ctrl_chk.sv
// Cycle-by-cycle rules for the interrupt file, attached by bind.
module msi_file_ctrl_chk
    import msi_file_pkg::*;
#(
    parameter int NBITS = 64,
    parameter int IDW   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_irq,
    input logic             deliver_q,
    input logic [TOP_W-1:0] thr_q,
    input logic [TOP_W-1:0] top_id,
    input logic [NBITS-1:0] pend_vec,
    input logic [NBITS-1:0] en_vec,
    input logic             claim_v,
    input logic             msg_set_v,
    input logic [IDW-1:0]   msg_set_id
);
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_q && (top_id != '0)) |=> ext_irq);

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(deliver_q && (top_id != '0)) |=> !ext_irq);

    p_id_zero_absent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_vec[0] && !en_vec[0]);

    p_top_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (top_id != '0) |-> (pend_vec[top_id] && en_vec[top_id]));

    p_top_below_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((thr_q != '0) && (top_id != '0)) |-> (top_id < thr_q));

    p_claim_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_v && !(msg_set_v && (TOP_W'(msg_set_id) == top_id))) |=> !pend_vec[$past(top_id)]);

    p_set_beats_claim_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_v && msg_set_v && (TOP_W'(msg_set_id) == top_id)) |=> pend_vec[$past(top_id)]);
endmodule

bind msi_file_ctrl msi_file_ctrl_chk #(.NBITS(NBITS), .IDW(IDW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_irq    (ext_irq),
    .deliver_q  (deliver_q),
    .thr_q      (thr_q),
    .top_id     (top_id),
    .pend_vec   (pend_vec),
    .en_vec     (en_vec),
    .claim_v    (claim_v),
    .msg_set_v  (msg_set_v),
    .msg_set_id (msg_set_id)
);

// File: tb/msi_file_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for the interrupt file, one task per scenario.
module msi_file_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        msg_valid;
    logic [11:0] msg_addr;
    logic [31:0] msg_data;
    logic [7:0]  reg_sel;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        seten_valid, clren_valid, clrpend_valid;
    logic [10:0] seten_num, clren_num, clrpend_num;
    logic        ext_irq;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    msi_file_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seten_valid(seten_valid), .seten_num(seten_num),
        .clren_valid(clren_valid), .clren_num(clren_num),
        .clrpend_valid(clrpend_valid), .clrpend_num(clrpend_num),
        .ext_irq(ext_irq)
    );

    function automatic logic [31:0] topv(input int id);
        return (32'(id) << 16) | 32'(id);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic mmio(input logic [11:0] a, input logic [31:0] d);
        msg_valid = 1'b1; msg_addr = a; msg_data = d;
        tick();
        msg_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] s, input logic [31:0] d);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] s, output logic [31:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic clear_all();
        wr(8'h80, 0); wr(8'h81, 0); wr(8'hC0, 0); wr(8'hC1, 0);
        wr(8'h72, 0); wr(8'h70, 0);
        tick();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h70, v); chk("R1 delivery", v, 0);
        rd(8'h72, v); chk("R1 threshold", v, 0);
        rd(8'h76, v); chk("R1 top", v, 0);
        rd(8'h80, v); chk("R1 pending0", v, 0);
        rd(8'hC1, v); chk("R1 enable1", v, 0);
        chk("R1 ext_irq", 32'(ext_irq), 0);
    endtask

    task automatic t_byte_order();
        logic [31:0] v;
        mmio(12'h000, 32'd5);
        rd(8'h80, v); chk("R2 little-endian id5", v, 32'h20);
        mmio(12'h004, 32'h2800_0000);
        rd(8'h81, v); chk("R2 big-endian id40", v, 32'h100);
        mmio(12'h008, 32'd7);
        rd(8'h80, v); chk("R2 other offset ignored", v, 32'h20);
        clear_all();
    endtask

    task automatic t_bad_ids();
        logic [31:0] v;
        mmio(12'h000, 32'd0);
        mmio(12'h000, 32'd64);
        mmio(12'h000, 32'h0001_0003);
        rd(8'h80, v); chk("R3 bad ids pend0", v, 0);
        rd(8'h81, v); chk("R3 bad ids pend1", v, 0);
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h80, v); chk("R3 id0 pending zero", v, 32'hFFFF_FFFE);
        wr(8'hC0, 32'hFFFF_FFFF);
        rd(8'hC0, v); chk("R3 id0 enable zero", v, 32'hFFFF_FFFE);
        clear_all();
    endtask

    task automatic t_slices();
        logic [31:0] v;
        wr(8'hC1, 32'hA5A5_0000);
        rd(8'hC1, v); chk("R4 enable slice1", v, 32'hA5A5_0000);
        rd(8'hC0, v); chk("R4 enable slice0 untouched", v, 0);
        wr(8'h81, 32'h0000_0F0F);
        rd(8'h81, v); chk("R4 pending slice1", v, 32'h0000_0F0F);
        wr(8'h82, 32'hFFFF_FFFF);
        rd(8'h82, v); chk("R4 unimplemented slice", v, 0);
        rd(8'h80, v); chk("R4 no alias to slice0", v, 0);
        clear_all();
    endtask

    task automatic t_priority();
        logic [31:0] v;
        mmio(12'h000, 32'd10);
        mmio(12'h000, 32'd3);
        mmio(12'h000, 32'd50);
        rd(8'h76, v); chk("R5 none enabled", v, 0);
        wr(8'hC0, 32'h400);
        wr(8'hC1, 32'h40000);
        rd(8'h76, v); chk("R5 lowest enabled", v, topv(10));
    endtask

    task automatic t_threshold();
        logic [31:0] v;
        wr(8'h72, 32'd10);
        rd(8'h72, v); chk("R6 threshold readback", v, 32'd10);
        rd(8'h76, v); chk("R6 T=10 masks 10 and 50", v, 0);
        wr(8'h72, 32'd11);
        rd(8'h76, v); chk("R6 T=11 passes 10", v, topv(10));
        wr(8'h72, 32'd0);
        rd(8'h76, v); chk("R6 T=0 no mask", v, topv(10));
    endtask

    task automatic t_delivery();
        tick();
        chk("R7 off keeps line low", 32'(ext_irq), 0);
        wr(8'h70, 32'd1);
        chk("R7 not yet raised", 32'(ext_irq), 0);
        tick();
        chk("R7 raised next cycle", 32'(ext_irq), 1);
        wr(8'h70, 32'd0);
        chk("R7 still high", 32'(ext_irq), 1);
        tick();
        chk("R7 lowered", 32'(ext_irq), 0);
        wr(8'h70, 32'd1);
        tick();
    endtask

    task automatic t_claim();
        logic [31:0] v;
        reg_sel = 8'h76; reg_wr = 1'b1; reg_wdata = 0;
        #1; chk("R8 claim returns 10", reg_rdata, topv(10));
        tick();
        #1; chk("R8 claim returns 50", reg_rdata, topv(50));
        tick();
        reg_wr = 1'b0;
        #1; chk("R8 drained", reg_rdata, 0);
        chk("R7 high until drain seen", 32'(ext_irq), 1);
        tick();
        chk("R7 low after drain", 32'(ext_irq), 0);
        rd(8'h80, v); chk("R8 disabled id3 kept", v, 32'h8);
        rd(8'h81, v); chk("R8 id50 cleared", v, 0);
    endtask

    task automatic t_by_number();
        logic [31:0] v;
        seten_valid = 1'b1; seten_num = 11'd3; tick(); seten_valid = 1'b0;
        rd(8'h76, v); chk("R9 set-enable 3", v, topv(3));
        clren_valid = 1'b1; clren_num = 11'd3; tick(); clren_valid = 1'b0;
        rd(8'h76, v); chk("R9 clear-enable 3", v, 0);
        seten_valid = 1'b1; seten_num = 11'd0; tick();
        seten_num = 11'd64; tick();
        seten_num = 11'd1088; tick(); seten_valid = 1'b0;
        rd(8'hC0, v); chk("R9 bad set-enable slice0", v, 32'h400);
        rd(8'hC1, v); chk("R9 bad set-enable slice1", v, 32'h40000);
        clrpend_valid = 1'b1; clrpend_num = 11'd3; tick(); clrpend_valid = 1'b0;
        rd(8'h80, v); chk("R9 clear-pending 3", v, 0);
        mmio(12'h000, 32'd5);
        clrpend_valid = 1'b1; clrpend_num = 11'd0; tick(); clrpend_valid = 1'b0;
        rd(8'h80, v); chk("R9 clear-pending 0 ignored", v, 32'h20);
        clrpend_valid = 1'b1; clrpend_num = 11'd5; tick(); clrpend_valid = 1'b0;
        rd(8'h80, v); chk("R9 clear-pending 5", v, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        seten_valid = 1'b1; seten_num = 11'd7; tick(); seten_valid = 1'b0;
        mmio(12'h000, 32'd7);
        rd(8'h76, v); chk("R10 top is 7", v, topv(7));
        msg_valid = 1'b1; msg_addr = 12'h000; msg_data = 32'd7;
        reg_sel = 8'h76; reg_wr = 1'b1;
        tick();
        msg_valid = 1'b0; reg_wr = 1'b0;
        rd(8'h80, v); chk("R10 set survives claim", v, 32'h80);
        wr(8'h76, 0);
        rd(8'h80, v); chk("R8 lone claim clears 7", v, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        msg_valid = 0; msg_addr = 0; msg_data = 0;
        reg_sel = 0; reg_wr = 0; reg_wdata = 0;
        seten_valid = 0; seten_num = 0;
        clren_valid = 0; clren_num = 0;
        clrpend_valid = 0; clrpend_num = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_byte_order();
        t_bad_ids();
        t_slices();
        t_priority();
        t_threshold();
        t_delivery();
        t_claim();
        t_by_number();
        t_set_wins();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule